// File: doc/BRIEF.md
# PWM-Synchronised ADC Convert-Start Delay

This block turns the low-side drive of one PWM channel into a timed trigger for an ADC sequencer. The low-side signal is active low, so its rising transition marks the end of the low-side on-time. Once the block sees that transition it counts a programmable number of clocks. If the low-side signal is still high when the count runs out, the block emits a one-clock convert-start pulse. One clock later a registered copy of that pulse goes to the ADC logic.

Software sets the block up through one 8-bit control register. The top bit arms the function. The low nibble picks the delay in steps of four clocks. If the low-side signal drops before the delay has elapsed, that PWM period produces no trigger. Each new low-side rising transition restarts the timing, and it uses the delay code in force at that transition.

Top module: `pwm_cnvst_delay`

## Requirements
- R1: After reset the control register reads 0x00, and `cnvst_o` and `cnvst_adc_o` are low.
- R2: While control bit 7 (enable) is 0, `cnvst_o` stays low whatever `lowside_i` does. A write takes effect at the clock edge that captures it.
- R3: With the enable bit set, code c in bits [3:0] gives a delay D = 4*(c+1) clocks (4 for 0000, 64 for 1111). The rising edge that first samples `lowside_i` high starts the count, and `cnvst_o` is high in the cycle after the D-th later edge.
- R4: If `lowside_i` is not sampled high on each of those D+1 consecutive edges, no convert start is produced for that period. A high pulse of exactly D+1 clocks still fires.
- R5: `cnvst_o` is high for exactly one clock per qualifying low-side high period, even when `lowside_i` stays high afterwards.
- R6: `cnvst_adc_o` equals `cnvst_o` delayed by exactly one clock.
- R7: Bits [6:4] of the control register read as 0 and ignore writes. Writing 0xFF reads back 0x8F.
- R8: A code written while a count is running leaves that count unchanged. The new code applies from the next low-side rising edge.
- R9: A low-side rising edge that occurs while the block is disabled is not remembered. Enabling the block while `lowside_i` is already high starts no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lowside_i | input | 1 | Active-low low-side PWM drive, synchronous to clk |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write value |
| reg_rd_data | output | 8 | Control register read value |
| cnvst_o | output | 1 | One-clock convert-start pulse |
| cnvst_adc_o | output | 1 | Convert start registered once more, for the ADC logic |

## Verification
The assertions assume that `lowside_i` is already synchronous to `clk` and free of glitches. They also assume that any pulse they check was preceded by at least four high samples, which holds only because the smallest delay code is four clocks. The stimulus changes `lowside_i` and the write port only on falling clock edges, and it gives every high and low phase a whole number of clocks. Pulse widths are chosen on both sides of each delay boundary, and writes are placed both between counts and inside them.

// File: rtl/cs_pkg.sv
// Package cs_pkg: shared constants and the decoded configuration type for
// the convert-start delay block. Assumes an 8-bit control register whose
// enable bit sits at the top and whose delay code sits in the low bits.
package cs_pkg;
    localparam int CS_REG_W  = 8;
    localparam int CS_CODE_W = 4;
    localparam int CS_EN_BIT = 7;

    typedef struct packed {
        logic                 en;
        logic [CS_CODE_W-1:0] code;
    } cs_cfg_t;
endpackage

// File: rtl/cs_ctrl_reg.sv
// Module cs_ctrl_reg: holds the enable bit and the delay code. Reserved
// bits are not stored, so they read back as zero. Assumes single-cycle
// write strobes synchronous to clk.
module cs_ctrl_reg
    import cs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CS_REG_W-1:0] wr_data,
    output cs_cfg_t             cfg,
    output logic [CS_REG_W-1:0] rd_data
);
    // Capture the enable bit and delay code on a write; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.en   <= wr_data[CS_EN_BIT];
            cfg.code <= wr_data[CS_CODE_W-1:0];
        end
    end

    // Rebuild the read value, with the reserved bits forced to zero.
    always_comb begin
        rd_data                  = '0;
        rd_data[CS_EN_BIT]       = cfg.en;
        rd_data[CS_CODE_W-1:0]   = cfg.code;
    end
endmodule

// File: rtl/cs_edge_det.sv
// Module cs_edge_det: finds the low-to-high transition of the low-side
// signal. It tracks the previous sample at all times, so a transition that
// happened while the block was disabled is not held over. Assumes sig is
// already synchronous to clk.
module cs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    // Keep the previous sample; reset treats the signal as low.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    // A rise is the current sample high while the previous one was low.
    always_comb rise = sig & ~prev_q;
endmodule

// File: rtl/cs_delay_timer.sv
// Module cs_delay_timer: loads STEP*(code+1) on a rise and counts down
// while the low side stays high. It emits one registered pulse when the
// count expires. A low sample, or the block being disabled, abandons the
// count. The code is used only at load time.
module cs_delay_timer #(
    parameter int CODE_W = 4,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic              rise,
    input  logic              level,
    output logic              fire
);
    localparam int MAX_DELAY = STEP << CODE_W;
    localparam int CNT_W     = $clog2(MAX_DELAY + 1);

    logic [CNT_W-1:0] remain_q;
    logic             active_q;
    logic [CNT_W-1:0] load_val;

    // Turn the delay code into a clock count.
    always_comb load_val = CNT_W'((int'(code) + 1) * STEP);

    // Run the countdown and issue the one-clock fire pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            active_q <= 1'b0;
            fire     <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!en) begin
                remain_q <= '0;
                active_q <= 1'b0;
            end else if (rise) begin
                remain_q <= load_val;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (!level) begin
                    remain_q <= '0;
                    active_q <= 1'b0;
                end else if (remain_q == CNT_W'(1)) begin
                    fire     <= 1'b1;
                    remain_q <= '0;
                    active_q <= 1'b0;
                end else begin
                    remain_q <= remain_q - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pwm_cnvst_delay.sv
// Module pwm_cnvst_delay: top of the PWM-timed ADC convert-start block.
// It connects the control register, the low-side edge detector and the
// delay timer, and registers the pulse once more for the ADC side.
// Assumes lowside_i is synchronous to clk.
module pwm_cnvst_delay
    import cs_pkg::*;
#(
    parameter int STEP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lowside_i,
    input  logic                reg_wr_en,
    input  logic [CS_REG_W-1:0] reg_wr_data,
    output logic [CS_REG_W-1:0] reg_rd_data,
    output logic                cnvst_o,
    output logic                cnvst_adc_o
);
    cs_cfg_t cfg;
    logic    ls_rise;

    cs_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .cfg     (cfg),
        .rd_data (reg_rd_data)
    );

    cs_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (lowside_i),
        .rise  (ls_rise)
    );

    cs_delay_timer #(
        .CODE_W (CS_CODE_W),
        .STEP   (STEP)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg.en),
        .code  (cfg.code),
        .rise  (ls_rise),
        .level (lowside_i),
        .fire  (cnvst_o)
    );

    // Add the one clock needed to hand the start over to the ADC logic.
    always_ff @(posedge clk) begin
        if (!rst_n) cnvst_adc_o <= 1'b0;
        else        cnvst_adc_o <= cnvst_o;
    end
endmodule

// File: rtl/pwm_cnvst_delay_chk.sv
// Module pwm_cnvst_delay_chk: port-level properties of pwm_cnvst_delay,
// attached through bind. Assumes lowside_i changes only between edges.
module pwm_cnvst_delay_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lowside_i,
    input logic [7:0] reg_rd_data,
    input logic       cnvst_o,
    input logic       cnvst_adc_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rd_data == 8'h00 && !cnvst_o && !cnvst_adc_o));

    assert_enabled_before_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |-> $past(reg_rd_data[7]));

    assert_min_delay_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |-> ($past(lowside_i, 4) && $past(lowside_i, 2)));

    assert_level_high_at_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |-> $past(lowside_i));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |=> !cnvst_o);

    assert_adc_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |=> cnvst_adc_o);

    assert_adc_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnvst_o |=> !cnvst_adc_o);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[6:4] == 3'b000);
endmodule

bind pwm_cnvst_delay pwm_cnvst_delay_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lowside_i   (lowside_i),
    .reg_rd_data (reg_rd_data),
    .cnvst_o     (cnvst_o),
    .cnvst_adc_o (cnvst_adc_o)
);

// File: tb/test_pwm_cnvst_delay.sv
`timescale 1ns/1ps
module test_pwm_cnvst_delay;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lowside_i = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       cnvst_o;
    logic       cnvst_adc_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int fires = 0;
    int fire_cyc = -1;
    int adc_cyc  = -1;

    // Behavioural reference state
    int  m_en = 0, m_code = 0, m_active = 0, m_target = 0, m_elapsed = 0;
    int  m_prev = 0, m_cnv = 0, m_adc = 0;
    bit  model_on = 1'b0;

    always #2.5 clk = ~clk;

    pwm_cnvst_delay i_pwm_cnvst_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .lowside_i   (lowside_i),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .cnvst_o     (cnvst_o),
        .cnvst_adc_o (cnvst_adc_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model and cycle count, advanced on every rising edge.
    always @(posedge clk) begin
        int nxt_cnv;
        cyc++;
        nxt_cnv = 0;
        if (!rst_n) begin
            m_en = 0; m_code = 0; m_active = 0; m_prev = 0; m_cnv = 0; m_adc = 0;
        end else begin
            if (m_en == 0) begin
                m_active = 0;
            end else if (lowside_i && m_prev == 0) begin
                m_active = 1; m_target = 4 * (m_code + 1); m_elapsed = 0;
            end else if (m_active == 1) begin
                if (!lowside_i) m_active = 0;
                else begin
                    m_elapsed++;
                    if (m_elapsed == m_target) begin nxt_cnv = 1; m_active = 0; end
                end
            end
            m_prev = lowside_i;
            m_adc  = m_cnv;
            m_cnv  = nxt_cnv;
            if (reg_wr_en) begin m_en = reg_wr_data[7]; m_code = reg_wr_data[3:0]; end
        end
    end

    // Compare against the model and log pulses half a period after each edge.
    always @(negedge clk) begin
        if (cnvst_o) begin fires++; fire_cyc = cyc; end
        if (cnvst_adc_o) adc_cyc = cyc;
        if (model_on) begin
            check("R3 cnvst_o vs model", cnvst_o, m_cnv);
            check("R6 cnvst_adc_o vs model", cnvst_adc_o, m_adc);
        end
    end

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // High phase of the given width, then a long low gap; returns the start edge.
    task automatic pulse(input int width, output int start);
        @(negedge clk);
        lowside_i = 1'b1;
        start = cyc + 1;
        fires = 0; fire_cyc = -1; adc_cyc = -1;
        repeat (width) @(negedge clk);
        lowside_i = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    initial begin
        int st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reg after reset", reg_rd_data, 8'h00);
        check("R1 cnvst_o after reset", cnvst_o, 0);
        check("R1 cnvst_adc_o after reset", cnvst_adc_o, 0);

        // R7: reserved bits read zero
        write_reg(8'hFF);
        check("R7 readback of 0xFF", reg_rd_data, 8'h8F);

        // R3: minimum delay, code 0
        write_reg(8'h80);
        pulse(10, st);
        check("R3 code0 fires once", fires, 1);
        check("R3 code0 latency", fire_cyc - st, 4);
        check("R6 adc one clock later", adc_cyc - fire_cyc, 1);

        // R3: maximum delay, code 15
        write_reg(8'h8F);
        pulse(70, st);
        check("R3 code15 latency", fire_cyc - st, 64);

        // R3: middle code 5
        write_reg(8'h85);
        pulse(30, st);
        check("R3 code5 latency", fire_cyc - st, 24);

        // R4: boundary with D = 16
        write_reg(8'h83);
        pulse(16, st);
        check("R4 width D suppressed", fires, 0);
        pulse(17, st);
        check("R4 width D+1 fires", fires, 1);
        check("R4 width D+1 latency", fire_cyc - st, 16);

        // R5: long high phase gives one pulse only
        write_reg(8'h80);
        pulse(200, st);
        check("R5 single pulse on long high", fires, 1);

        // R2: disabled block stays quiet
        write_reg(8'h03);
        pulse(40, st);
        check("R2 disabled no pulse", fires, 0);

        // R9: enabling while already high starts nothing
        @(negedge clk);
        lowside_i = 1'b1;
        fires = 0;
        repeat (3) @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 8'h80;
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (40) @(negedge clk);
        lowside_i = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 stale rise ignored", fires, 0);

        // R8: code change inside a count applies from the next rise
        @(negedge clk);
        lowside_i = 1'b1;
        st = cyc + 1;
        fires = 0; fire_cyc = -1;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 8'h87;
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (40) @(negedge clk);
        lowside_i = 1'b0;
        repeat (10) @(negedge clk);
        check("R8 running count keeps old code", fire_cyc - st, 4);
        pulse(40, st);
        check("R8 next rise uses new code", fire_cyc - st, 32);

        // R2: disable in mid-count abandons it
        @(negedge clk);
        lowside_i = 1'b1;
        fires = 0;
        repeat (5) @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = 8'h07;
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (40) @(negedge clk);
        lowside_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R2 disable aborts count", fires, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule